// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block drives the four gate enables of one full H-bridge: upper-left, upper-right, lower-left and lower-right. It takes a requested bridge mode (charge, slow decay or fast decay) and a current-direction bit and maps them to a gate pattern. Whenever the effective mode or the direction changes, all four gates are held off for a programmable number of clock cycles before the new pattern is applied, so that the two switches of a half-bridge never conduct together.

Two global force-off conditions override the pattern. A low bridge enable turns every gate off in the same cycle, and the coil then discharges through the body diodes. An over-temperature bit, synchronized inside the block, also turns every gate off and drives the protect output, which models an open-drain pull-down. The mode and dead-time logic keeps running while the gates are forced off, so the bridge resumes with whatever pattern is current when the force-off ends.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Gate vectors are written {U1,U2,L1,L2}. Mode code 00 is charge and 10 is fast decay. With direction 0, charge drives 1001 and fast drives 0110.
- R2: With direction 1, charge drives 0110 and fast drives 1001.
- R3: Mode code 01 is slow decay and drives 0011 in both directions. Mode code 11 is treated exactly as 01, so a change between 01 and 11 is not a mode change.
- R4: From the first rising edge that samples a changed effective mode or direction, all four gates are off for exactly DEAD_CYC cycles. The new pattern then appears. An unchanged effective request never turns the gates off.
- R5: A request that changes again during a dead window does not lengthen the window. At the end of the window, the request present at that time is applied.
- R6: A low bridge_en forces all gates off in the same cycle. The mode sequencer keeps advancing, so when bridge_en rises, the pattern for the current request appears at once with no extra dead time.
- R7: ot_in passes through a two-flop synchronizer. From the second rising edge at which it is high, prot_pull_low is 1 and all gates are off. Both are released two edges after ot_in falls.
- R8: During reset, all gates are off and prot_pull_low is 0. After reset is released, the requested pattern first appears on the DEAD_CYC-th rising edge.
- R9: U1 and L1 are never on together, and U2 and L2 are never on together. Any change between two non-off patterns passes through an all-off cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | 1 | 1 allows gate drive; 0 turns all gates off |
| mode_req | input | 2 | Requested mode: 00 charge, 01/11 slow, 10 fast |
| dir_req | input | 1 | Current direction |
| ot_in | input | 1 | Over-temperature indication (asynchronous) |
| gate_u1 | output | 1 | Upper-left gate enable |
| gate_u2 | output | 1 | Upper-right gate enable |
| gate_l1 | output | 1 | Lower-left gate enable |
| gate_l2 | output | 1 | Lower-right gate enable |
| prot_pull_low | output | 1 | 1 = protect flag pulled low; 0 = released |

## Verification
The interesting overlap is a force-off that falls inside a dead window. The bench drops bridge_en while the bridge holds one pattern, then changes the request while the gates are forced off. It waits longer than the dead time and raises bridge_en again. The check is that the new pattern appears in the same cycle, with no extra all-off gap. Over-temperature is checked the same way, against the two-edge synchronizer latency and its release. All 64 ordered pairs of (mode code, direction) are swept to judge the dead-time length and the pattern that follows it. A second request issued mid-window shows that the window is not restarted.

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int DEAD_CYC = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_en,
  input  logic [1:0] mode_req,
  input  logic       dir_req,
  input  logic       ot_in,
  output logic       gate_u1,
  output logic       gate_u2,
  output logic       gate_l1,
  output logic       gate_l2,
  output logic       prot_pull_low
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [1:0] M_CHARGE = 2'b00;
  localparam logic [1:0] M_SLOW   = 2'b01;
  localparam logic [1:0] M_FAST   = 2'b10;

  logic [1:0]    mode_eff;
  logic [2:0]    key_req, key_cur;
  logic [CW-1:0] dead_cnt;
  logic          ot_s1, ot_s2;
  logic [3:0]    pat, gates;

  assign mode_eff = (mode_req == 2'b11) ? M_SLOW : mode_req;
  assign key_req  = {mode_eff, dir_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_cur  <= {M_SLOW, 1'b0};
      dead_cnt <= CW'(DEAD_CYC);
      ot_s1    <= 1'b0;
      ot_s2    <= 1'b0;
    end else begin
      ot_s1 <= ot_in;
      ot_s2 <= ot_s1;
      if (dead_cnt == CW'(1)) begin
        key_cur  <= key_req;
        dead_cnt <= '0;
      end else if (dead_cnt != '0) begin
        dead_cnt <= dead_cnt - CW'(1);
      end else if (key_req != key_cur) begin
        dead_cnt <= CW'(DEAD_CYC);
      end
    end
  end

  always_comb begin
    case (key_cur[2:1])
      M_CHARGE: pat = key_cur[0] ? 4'b0110 : 4'b1001;
      M_FAST:   pat = key_cur[0] ? 4'b1001 : 4'b0110;
      default:  pat = 4'b0011;
    endcase
  end

  assign gates = (bridge_en && !ot_s2 && dead_cnt == '0) ? pat : 4'b0000;
  assign {gate_u1, gate_u2, gate_l1, gate_l2} = gates;
  assign prot_pull_low = ot_s2;

  assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_u1 && gate_l1) && !(gate_u2 && gate_l2));

  assert_change_via_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gates) && (|$past(gates))) |-> (gates == $past(gates)));

  assert_protect_forces_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_pull_low |-> (gates == 4'b0000));

  assert_ot_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_in && $past(ot_in)) |=> prot_pull_low);
endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int DEAD  = 3;

  logic clk = 1'b0, rst_n = 1'b0, bridge_en = 1'b0, dir_req = 1'b0, ot_in = 1'b0;
  logic [1:0] mode_req = 2'b01;
  logic u1, u2, l1, l2, prot;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .mode_req(mode_req),
    .dir_req(dir_req), .ot_in(ot_in), .gate_u1(u1), .gate_u2(u2),
    .gate_l1(l1), .gate_l2(l2), .prot_pull_low(prot));

  function automatic logic [3:0] exp_pat(input logic [1:0] m, input logic d);
    if (m == 2'b00) return d ? 4'b0110 : 4'b1001;
    if (m == 2'b10) return d ? 4'b1001 : 4'b0110;
    return 4'b0011;
  endfunction

  function automatic logic [2:0] eff_key(input logic [2:0] k);
    return {(k[2:1] == 2'b11) ? 2'b01 : k[2:1], k[0]};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_key(input logic [2:0] k);
    mode_req = k[2:1]; dir_req = k[0];
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] g;
    bridge_en = 1'b1;
    set_key(3'b000);
    repeat (3) step();
    chk("R8 reset gates off", {u1,u2,l1,l2}, 4'b0000);
    chk("R8 reset protect released", {3'b0, prot}, 4'b0000);
    rst_n = 1'b1;
    for (int i = 1; i < DEAD; i++) begin
      step();
      chk("R8 off after reset", {u1,u2,l1,l2}, 4'b0000);
    end
    step();
    chk("R8/R1 first pattern after reset", {u1,u2,l1,l2}, 4'b1001);

    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [2:0] ka, kb;
        logic bad;
        ka = 3'(a); kb = 3'(b);
        set_key(ka);
        repeat (DEAD + 3) step();
        chk("R1/R2/R3 settled pattern", {u1,u2,l1,l2}, exp_pat(ka[2:1], ka[0]));
        set_key(kb);
        bad = 1'b0;
        if (eff_key(ka) == eff_key(kb)) begin
          for (int i = 1; i <= DEAD + 1; i++) begin
            step();
            if ({u1,u2,l1,l2} !== exp_pat(ka[2:1], ka[0])) bad = 1'b1;
          end
          checks++;
          if (bad) begin
            errors++;
            $display("FAIL R3/R4 no dead time %0d->%0d: actual %b expected %b",
                     a, b, {u1,u2,l1,l2}, exp_pat(ka[2:1], ka[0]));
          end
        end else begin
          for (int i = 1; i <= DEAD; i++) begin
            step();
            if ({u1,u2,l1,l2} !== 4'b0000) bad = 1'b1;
          end
          g = {u1,u2,l1,l2};
          checks++;
          if (bad) begin
            errors++;
            $display("FAIL R4 dead window %0d->%0d: actual %b expected 0000", a, b, g);
          end
          step();
          chk("R4 pattern after dead window", {u1,u2,l1,l2}, exp_pat(kb[2:1], kb[0]));
        end
      end
    end

    set_key(3'b000); repeat (DEAD + 3) step();
    set_key(3'b100);
    step();
    set_key(3'b001);
    for (int i = 2; i <= DEAD; i++) step();
    chk("R5 window not extended (still off)", {u1,u2,l1,l2}, 4'b0000);
    step();
    chk("R5 latest request applied", {u1,u2,l1,l2}, 4'b0110);
    step();
    chk("R5 stays on latest", {u1,u2,l1,l2}, 4'b0110);

    set_key(3'b000); repeat (DEAD + 3) step();
    bridge_en = 1'b0; #1;
    chk("R6 enable low immediate off", {u1,u2,l1,l2}, 4'b0000);
    set_key(3'b100);
    repeat (DEAD + 3) step();
    chk("R6 off while disabled", {u1,u2,l1,l2}, 4'b0000);
    bridge_en = 1'b1; #1;
    chk("R6 resume with advanced pattern", {u1,u2,l1,l2}, 4'b0110);

    step();
    ot_in = 1'b1;
    step();
    chk("R7 one edge: still driving", {prot,u1,u2,l1}, 4'b0011);
    step();
    chk("R7 protect asserted", {3'b0, prot}, 4'b0001);
    chk("R7 gates off", {u1,u2,l1,l2}, 4'b0000);
    ot_in = 1'b0;
    step();
    chk("R7 still held one edge after clear", {3'b0, prot}, 4'b0001);
    step();
    chk("R7 protect released", {3'b0, prot}, 4'b0000);
    chk("R7 gates restored", {u1,u2,l1,l2}, 4'b0110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule